// File: doc/BRIEF.md
# Inband Loopback Code Detector

This block watches a received T1 bit stream for a loop-activate or a loop-deactivate code, each a short bit pattern sent over and over. It keeps two independent detection channels. Each channel compares every counted bit against its expected pattern at every possible alignment. A bit-valid strobe marks each bit. A 1 ms timebase tick cuts time into windows. A channel whose pattern has held, within an error allowance, for 48 windows in a row raises its status level.

The codes come in on register-style inputs: a pattern of up to eight bits plus a length from 1 to 8. The bit at position `len-1` of the pattern goes on the line first. With the usual settings the activate code is `5'b00001` with length 5, and the deactivate code is `3'b001` with length 3. The code may either fill the whole stream or be broken up by framing bits. In framed mode, bits that carry the framing marker are left out of comparison and counting.

When a status level rises, it sets a latched interrupt flag that stays set until a clear pulse arrives. The interrupt output is active when any flag is set and its mask bit is zero.

Top module: `loop_code_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, actStatus, deactStatus, actFlag, deactFlag and irq are all 0.
- R2: With the activate code (5'b00001, length 5) repeated on the line and no errors, actStatus rises in the cycle after the 48th consecutive good window ends. After only 47 windows it is still 0.
- R3: The deactivate channel detects its own code (3'b001, length 3) in the same way and asserts deactStatus only, not actStatus.
- R4: Detection does not depend on the alignment at which the stream starts relative to window or reset boundaries. Any starting phase of the repeating code is recognised.
- R5: The code pattern and its length (1 to 8) are programmable per channel. Pattern bit len-1 is the first bit on the line. An 8-bit code and a 1-bit code are both recognised.
- R6: When framedMode is 1, a bit with frameBit=1 is skipped. When framedMode is 0, every valid bit is counted, so a framed stream containing the code is not detected.
- R7: A window is good when it counted at least one bit and some phase had no more than errLimit mismatches in it. A bad window drops the status to 0 and restarts the persistence count.
- R8: A flag sets on the rising edge of its status and holds, even after the status falls, until its clear input pulses. A status that stays high does not set the flag again after a clear.
- R9: irq = (actFlag and actMask=0) or (deactFlag and deactMask=0). A mask bit of 1 blocks irq but leaves the flag unchanged.
- R10: A stream that is not a repeating code never asserts either status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Received line bit |
| bitValid | input | 1 | bitIn carries a bit this cycle |
| frameBit | input | 1 | Current bit is a framing bit |
| framedMode | input | 1 | 1: skip framing bits |
| winTick | input | 1 | One-cycle pulse closing a 1 ms window |
| actCode | input | MAX_LEN | Activate pattern, bit len-1 first |
| actLen | input | LEN_W | Activate pattern length, 1..MAX_LEN |
| deactCode | input | MAX_LEN | Deactivate pattern |
| deactLen | input | LEN_W | Deactivate pattern length |
| errLimit | input | CNT_W | Largest mismatch count per window still judged good |
| actMask | input | 1 | 1 masks the activate interrupt |
| deactMask | input | 1 | 1 masks the deactivate interrupt |
| actClr | input | 1 | Clear pulse for actFlag |
| deactClr | input | 1 | Clear pulse for deactFlag |
| actStatus | output | 1 | Activate code present |
| deactStatus | output | 1 | Deactivate code present |
| actFlag | output | 1 | Latched activate event |
| deactFlag | output | 1 | Latched deactivate event |
| irq | output | 1 | Unmasked interrupt request |

## Verification
The bench targets the edges of persistence: 47 windows must not assert and 48 must. A design that counted off by one, or that counted the partial first window, would assert early or late. Streams start at several phase offsets and use 8-bit and 1-bit codes. A detector that locked to one alignment, or reversed the pattern's bit order, would miss them. An error allowance of exactly errLimit must pass and one more mismatch must fail, and a framed stream is sent with framedMode both set and cleared. A bad window, a clear while status stays high, and a masked flag show whether the status drops, whether the flag is truly edge-set and latched, and whether the mask gates only irq.

// File: rtl/loop_code_pkg.sv
package loop_code_pkg;
  typedef struct packed {
    logic bitEn;
    logic winEnd;
  } lcd_strobe_t;
endpackage

// File: rtl/lcd_datapath.sv
module lcd_datapath
  import loop_code_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = 8,
  parameter int PERSIST = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  lcd_strobe_t        strb,
  input  logic               bitIn,
  input  logic [MAX_LEN-1:0] code,
  input  logic [LEN_W-1:0]   len,
  input  logic [CNT_W-1:0]   errLimit,
  output logic               status
);
  localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int PCNT_W  = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0]  effLen;
  logic [LEN_W-1:0]  idx;
  logic [CNT_W-1:0]  misCnt [MAX_LEN];
  logic [MAX_LEN-1:0] refBit;
  logic              anyBit;
  logic              winGood;
  logic [PCNT_W-1:0] persistCnt;

  always_comb begin
    if (len == '0)                        effLen = LEN_W'(1);
    else if (len > LEN_W'(MAX_LEN))       effLen = LEN_W'(MAX_LEN);
    else                                  effLen = len;
  end

  always_ff @(posedge clk) begin
    if (!rstN) idx <= '0;
    else if (strb.bitEn) idx <= (idx >= effLen - LEN_W'(1)) ? '0 : idx + LEN_W'(1);
  end

  for (genvar j = 0; j < MAX_LEN; j++) begin : g_phase
    logic [LEN_W:0] posRaw, posWrap, sel;
    logic           miss;
    always_comb begin
      posRaw  = {1'b0, idx} + (LEN_W+1)'(j);
      posWrap = (posRaw >= {1'b0, effLen}) ? posRaw - {1'b0, effLen} : posRaw;
      sel     = {1'b0, effLen} - (LEN_W+1)'(1) - posWrap;
    end
    assign refBit[j] = code[sel[IDX_W-1:0]];
    assign miss      = bitIn ^ refBit[j];
    always_ff @(posedge clk) begin
      if (!rstN) misCnt[j] <= '0;
      else if (strb.winEnd) misCnt[j] <= (strb.bitEn && miss) ? CNT_W'(1) : '0;
      else if (strb.bitEn && miss && misCnt[j] != CNT_MAX) misCnt[j] <= misCnt[j] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) anyBit <= 1'b0;
    else if (strb.winEnd) anyBit <= strb.bitEn;
    else if (strb.bitEn) anyBit <= 1'b1;
  end

  always_comb begin
    winGood = 1'b0;
    for (int j = 0; j < MAX_LEN; j++)
      if (LEN_W'(j) < effLen && misCnt[j] <= errLimit) winGood = 1'b1;
    winGood = winGood & anyBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      persistCnt <= '0;
      status     <= 1'b0;
    end else if (strb.winEnd) begin
      if (winGood) begin
        if (persistCnt != PCNT_W'(PERSIST)) persistCnt <= persistCnt + PCNT_W'(1);
        status <= (persistCnt >= PCNT_W'(PERSIST - 1));
      end else begin
        persistCnt <= '0;
        status     <= 1'b0;
      end
    end
  end

  // R2
  persist_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    persistCnt <= PCNT_W'(PERSIST));
  // R7
  bad_window_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.winEnd && !winGood |=> !status && persistCnt == '0);
  // R2
  status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status) |-> $past(strb.winEnd));
endmodule

// File: rtl/lcd_ctrl.sv
module lcd_ctrl
  import loop_code_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        frameBit,
  input  logic        framedMode,
  input  logic        winTick,
  input  logic [1:0]  status,
  input  logic [1:0]  mask,
  input  logic [1:0]  clr,
  output lcd_strobe_t strb,
  output logic [1:0]  flag,
  output logic        irq
);
  logic [1:0] statusQ;
  logic [1:0] rise;

  assign strb.bitEn  = bitValid & ~(framedMode & frameBit);
  assign strb.winEnd = winTick;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    assign rise[c] = status[c] & ~statusQ[c];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[c] <= 1'b0;
        flag[c]    <= 1'b0;
      end else begin
        statusQ[c] <= status[c];
        flag[c]    <= (flag[c] & ~clr[c]) | rise[c];
      end
    end
  end

  assign irq = |(flag & ~mask);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[0] && !statusQ[0] |=> flag[0]);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flag[1] && !clr[1] |=> flag[1]);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flag[0] && !flag[1] |-> !irq);
endmodule

// File: rtl/loop_code_detect.sv
module loop_code_detect
  import loop_code_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = 8,
  parameter int PERSIST = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic               bitValid,
  input  logic               frameBit,
  input  logic               framedMode,
  input  logic               winTick,
  input  logic [MAX_LEN-1:0] actCode,
  input  logic [LEN_W-1:0]   actLen,
  input  logic [MAX_LEN-1:0] deactCode,
  input  logic [LEN_W-1:0]   deactLen,
  input  logic [CNT_W-1:0]   errLimit,
  input  logic               actMask,
  input  logic               deactMask,
  input  logic               actClr,
  input  logic               deactClr,
  output logic               actStatus,
  output logic               deactStatus,
  output logic               actFlag,
  output logic               deactFlag,
  output logic               irq
);
  lcd_strobe_t strb;
  logic [1:0]  flagVec;

  lcd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .frameBit(frameBit),
    .framedMode(framedMode), .winTick(winTick),
    .status({deactStatus, actStatus}), .mask({deactMask, actMask}),
    .clr({deactClr, actClr}), .strb(strb), .flag(flagVec), .irq(irq)
  );

  lcd_datapath #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W), .PERSIST(PERSIST)) u_act (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn), .code(actCode),
    .len(actLen), .errLimit(errLimit), .status(actStatus)
  );

  lcd_datapath #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W), .PERSIST(PERSIST)) u_deact (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn), .code(deactCode),
    .len(deactLen), .errLimit(errLimit), .status(deactStatus)
  );

  assign actFlag   = flagVec[0];
  assign deactFlag = flagVec[1];
endmodule

// File: tb/tb_loop_code_detect.sv
module tb_loop_code_detect;
  logic clk = 1'b0;
  logic rstN, bitIn, bitValid, frameBit, framedMode, winTick;
  logic [7:0] actCode, deactCode, errLimit;
  logic [3:0] actLen, deactLen;
  logic actMask, deactMask, actClr, deactClr;
  logic actStatus, deactStatus, actFlag, deactFlag, irq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  loop_code_detect dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .frameBit(frameBit),
    .framedMode(framedMode), .winTick(winTick), .actCode(actCode), .actLen(actLen),
    .deactCode(deactCode), .deactLen(deactLen), .errLimit(errLimit),
    .actMask(actMask), .deactMask(deactMask), .actClr(actClr), .deactClr(deactClr),
    .actStatus(actStatus), .deactStatus(deactStatus), .actFlag(actFlag),
    .deactFlag(deactFlag), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] aCode; logic [3:0] aLen; logic [7:0] dCode; logic [3:0] dLen;
    logic [7:0] sCode; logic [3:0] sLen; logic [3:0] phase;
    logic fs; logic fm; logic [3:0] errs; logic [7:0] limit; logic [7:0] nWin;
    logic rnd; logic expA; logic expD;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd0, 1'b0,1'b0,4'd0,8'd0,8'd50, 1'b0,1'b1,1'b0}, // R2
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd3,4'd1, 1'b0,1'b0,4'd0,8'd0,8'd50, 1'b0,1'b0,1'b1}, // R3
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd3, 1'b0,1'b0,4'd0,8'd0,8'd50, 1'b0,1'b1,1'b0}, // R4
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd2, 1'b1,1'b1,4'd0,8'd0,8'd50, 1'b0,1'b1,1'b0}, // R6
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd2, 1'b1,1'b0,4'd0,8'd0,8'd50, 1'b0,1'b0,1'b0}, // R6
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd0, 1'b0,1'b0,4'd2,8'd2,8'd50, 1'b0,1'b1,1'b0}, // R7
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd0, 1'b0,1'b0,4'd3,8'd2,8'd50, 1'b0,1'b0,1'b0}, // R7
    '{8'hB2,4'd8,8'h01,4'd3, 8'hB2,4'd8,4'd5, 1'b0,1'b0,4'd0,8'd0,8'd50, 1'b0,1'b1,1'b0}, // R5
    '{8'h01,4'd1,8'h01,4'd3, 8'h01,4'd1,4'd0, 1'b0,1'b0,4'd0,8'd0,8'd50, 1'b0,1'b1,1'b0}, // R5
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd0, 1'b0,1'b0,4'd0,8'd0,8'd50, 1'b1,1'b0,1'b0}, // R10
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd0, 1'b0,1'b0,4'd0,8'd0,8'd47, 1'b0,1'b0,1'b0}, // R2
    '{8'h01,4'd5,8'h01,4'd3, 8'h01,4'd5,4'd4, 1'b0,1'b0,4'd0,8'd0,8'd48, 1'b0,1'b1,1'b0}  // R2
  };

  // stream generator state
  logic [7:0] sCode; logic [3:0] sLen; logic fs, rnd; logic [3:0] errs;
  int pos, fcnt; logic [15:0] lfsr;

  task automatic check(input string tag, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic runWin(input int n);
    for (int w = 0; w < n; w++) begin
      int errCnt = 0;
      for (int b = 0; b < 40; b++) begin
        @(negedge clk);
        winTick = 1'b0; bitValid = 1'b1;
        if (fs && fcnt == 192) begin
          frameBit = 1'b1; bitIn = 1'b1; fcnt = 0;
        end else begin
          frameBit = 1'b0; fcnt++;
          if (rnd) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bitIn = lfsr[0];
          end else begin
            bitIn = sCode[sLen - 4'd1 - 4'(pos)] ^ (errCnt < int'(errs));
            pos = (pos + 1) % int'(sLen);
          end
          if (errCnt < int'(errs)) errCnt++;
        end
      end
      @(negedge clk);
      bitValid = 1'b0; frameBit = 1'b0; winTick = 1'b1;
    end
    @(negedge clk);
    winTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; bitValid = 1'b0; winTick = 1'b0; frameBit = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    pos = 0; fcnt = 0;
  endtask

  initial begin
    #1600000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; bitIn = 1'b0; bitValid = 1'b0; frameBit = 1'b0; framedMode = 1'b0;
    winTick = 1'b0; actCode = 8'h01; actLen = 4'd5; deactCode = 8'h01; deactLen = 4'd3;
    errLimit = 8'd0; actMask = 1'b0; deactMask = 1'b0; actClr = 1'b0; deactClr = 1'b0;
    lfsr = 16'hACE1; sCode = 8'h01; sLen = 4'd5; fs = 1'b0; rnd = 1'b0; errs = 4'd0;
    pos = 0; fcnt = 0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 actStatus in reset", actStatus, 1'b0);
    check("R1 flags in reset", actFlag | deactFlag, 1'b0);
    check("R1 irq in reset", irq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", actStatus | deactStatus | irq, 1'b0);

    for (int v = 0; v < NV; v++) begin
      doReset();
      @(negedge clk);
      rstN = 1'b0;
      actCode = VECS[v].aCode; actLen = VECS[v].aLen;
      deactCode = VECS[v].dCode; deactLen = VECS[v].dLen;
      framedMode = VECS[v].fm; errLimit = VECS[v].limit;
      sCode = VECS[v].sCode; sLen = VECS[v].sLen; fs = VECS[v].fs;
      rnd = VECS[v].rnd; errs = VECS[v].errs;
      @(negedge clk);
      rstN = 1'b1;
      pos = int'(VECS[v].phase) % int'(sLen); fcnt = 0;
      runWin(int'(VECS[v].nWin));
      check($sformatf("vector %0d actStatus (R2 R3 R4 R5 R6 R7 R10)", v), actStatus, VECS[v].expA);
      check($sformatf("vector %0d deactStatus (R3 R10)", v), deactStatus, VECS[v].expD);
    end

    // directed: flags, masks, clear, bad window
    @(negedge clk); rstN = 1'b0;
    actCode = 8'h01; actLen = 4'd5; deactCode = 8'h01; deactLen = 4'd3;
    framedMode = 1'b0; errLimit = 8'd0; sCode = 8'h01; sLen = 4'd5;
    fs = 1'b0; rnd = 1'b0; errs = 4'd0; actMask = 1'b0; deactMask = 1'b0;
    @(negedge clk); rstN = 1'b1; pos = 0; fcnt = 0;
    runWin(48);
    check("R2 actStatus after 48 windows", actStatus, 1'b1);
    check("R8 actFlag set on rise", actFlag, 1'b1);
    check("R8 deactFlag untouched", deactFlag, 1'b0);
    check("R9 irq unmasked", irq, 1'b1);
    actMask = 1'b1;
    @(negedge clk);
    check("R9 irq masked", irq, 1'b0);
    check("R9 flag kept under mask", actFlag, 1'b1);
    actMask = 1'b0;
    actClr = 1'b1;
    @(negedge clk);
    actClr = 1'b0;
    @(negedge clk);
    check("R8 flag cleared", actFlag, 1'b0);
    check("R9 irq after clear", irq, 1'b0);
    runWin(2);
    check("R8 status still high", actStatus, 1'b1);
    check("R8 no re-set while status high", actFlag, 1'b0);
    rnd = 1'b1;
    runWin(1);
    check("R7 bad window drops status", actStatus, 1'b0);
    rnd = 1'b0;
    runWin(47);
    check("R7 persistence restarted", actStatus, 1'b0);
    runWin(1);
    check("R7 status back after 48 more", actStatus, 1'b1);
    check("R8 flag set again", actFlag, 1'b1);
    rnd = 1'b1;
    runWin(1);
    check("R8 flag holds after status falls", actFlag, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule